// File: doc/BRIEF.md
# Sign-Randomized Hadamard Rotator

This block applies a randomized orthogonal rotation to a vector of `D` signed samples (default 128). Samples stream in one per cycle. A per-layer pattern of sign flips is taken from a constant table, and the flips are applied to the buffered vector. A fast Walsh-Hadamard transform built only from adders and subtractors then runs over the result. The rotated vector streams out one element per cycle, scaled down by a right shift with rounding.

The same unit serves key vectors on the write path and query vectors on the read path. Because both pass through the identical sign pattern and transform, inner products are kept up to a fixed gain. Retuning the sign patterns changes only the table contents, not the datapath. The remaining factor of 1/sqrt(2) in the 1/sqrt(128) normalization is left to the downstream quantizer thresholds.

The transform uses a constant-geometry form. One perfect-shuffle butterfly layer of `D/2` add/subtract pairs is applied `log2(D)` times to a register file. That sequence gives the Sylvester-ordered Hadamard result in natural index order.

Top module: `hadamard_rotator`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid` and `out_last` are 0.
- R2: Element j of a vector is taken on the j-th cycle in which `in_valid` and `in_ready` are both high. From the cycle after the D-th element is taken, `in_ready` stays low until the cycle after the one carrying `out_last`, and then it returns high.
- R3: The layer number is captured from `layer_sel` together with element 0. Values of `layer_sel` presented with the other elements have no effect on the result.
- R4: For layer L, input element j is negated when bit 5 XOR bit 2 of h = (j*j + 5*L*j + 3*L + 1) mod 256 is 1. Otherwise it passes unchanged. Each of the 2^LW layers has its own pattern.
- R5: Let z be the sign-adjusted vector. The unscaled output element i is y_i = sum over j of z_j, negated where popcount(i AND j) is odd. This is the Sylvester-ordered Walsh-Hadamard transform in natural order, computed without multipliers.
- R6: Each output is (y_i + 4) arithmetically shifted right by 3 (SCALE_SHIFT = 3), as a signed IW+5-bit value. Full-scale inputs, where every sign-adjusted element equals +2^(IW-1), must not overflow the datapath.
- R7: Suppose the last input element is presented at a falling edge and taken at the next rising edge. Then `out_valid` is first seen high at the ninth falling edge after that one (log2(D)+2). It stays high for exactly D consecutive cycles, carrying elements 0..D-1 in order, with `out_last` high only on element D-1.
- R8: `in_valid` asserted while `in_ready` is low is ignored. Neither the vector being processed nor the next vector is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block is collecting a vector |
| in_data | input | IW (16) | Signed input sample |
| layer_sel | input | LW (5) | Layer whose sign pattern applies; used with element 0 |
| out_valid | output | 1 | Output sample present |
| out_last | output | 1 | Marks element D-1 of the output vector |
| out_data | output | IW+log2(D)+1-SCALE_SHIFT (21) | Signed rotated, scaled sample |

## Verification
The assertions assume the upstream side offers samples only through the `in_valid`/`in_ready` handshake and keeps to the signed IW-bit range. They also assume no reset occurs in the middle of a vector. The bench drives every input at the falling edge and samples every output there. Its data values are bounded by the extremes of the IW-bit range, including the case where every flipped element reaches the maximum magnitude, so the butterfly overflow property is exercised at its limit. It also raises `in_valid` with junk data throughout the compute and drain phases, which tests the claim that the handshake alone gates capture.

// File: rtl/hadr_pkg.sv
package hadr_pkg;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_SIGN  = 2'd1,
    PH_XFORM = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;

  // Sign-flip decision for one element of one layer's pattern.
  function automatic logic flip_bit(input int unsigned layer, input int unsigned idx);
    logic [7:0] h;
    h = 8'((idx * idx + 5 * layer * idx + 3 * layer + 1) & 32'd255);
    return h[5] ^ h[2];
  endfunction

endpackage

// File: rtl/hadr_sign_rom.sv
module hadr_sign_rom #(
  parameter int D  = 128,
  parameter int LW = 5
) (
  input  logic [LW-1:0] layer,
  output logic [D-1:0]  mask
);
  localparam int NUM_LAYERS = 1 << LW;

  // One pattern row, built from the package rule at elaboration.
  function automatic logic [D-1:0] pattern_row(input int unsigned l);
    logic [D-1:0] r;
    for (int i = 0; i < D; i++) r[i] = hadr_pkg::flip_bit(l, i);
    return r;
  endfunction

  logic [D-1:0] rom_w [NUM_LAYERS];

  for (genvar gl = 0; gl < NUM_LAYERS; gl++) begin : g_row
    assign rom_w[gl] = pattern_row(gl);
  end

  assign mask = rom_w[layer];

endmodule

// File: rtl/hadr_shuffle_stage.sv
module hadr_shuffle_stage #(
  parameter int D  = 128,
  parameter int AW = 24
) (
  input  logic signed [AW-1:0] x [D],
  output logic signed [AW-1:0] y [D],
  output logic                 ovf
);
  localparam int HALF = D / 2;

  logic [HALF-1:0] ovf_sum;
  logic [HALF-1:0] ovf_dif;

  for (genvar k = 0; k < HALF; k++) begin : g_bfly
    logic signed [AW:0] a_ext;
    logic signed [AW:0] b_ext;
    logic signed [AW:0] s_w;
    logic signed [AW:0] d_w;
    assign a_ext = {x[k][AW-1], x[k]};
    assign b_ext = {x[k+HALF][AW-1], x[k+HALF]};
    assign s_w   = a_ext + b_ext;
    assign d_w   = a_ext - b_ext;
    assign y[2*k]     = s_w[AW-1:0];
    assign y[2*k+1]   = d_w[AW-1:0];
    assign ovf_sum[k] = s_w[AW] ^ s_w[AW-1];
    assign ovf_dif[k] = d_w[AW] ^ d_w[AW-1];
  end

  assign ovf = |ovf_sum | |ovf_dif;

endmodule

// File: rtl/hadr_ctrl.sv
module hadr_ctrl #(
  parameter int D     = 128,
  parameter int LOG2D = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output hadr_pkg::phase_e      phase,
  output logic [LOG2D-1:0]      elem_idx,
  output logic                  accept,
  output logic                  accept_first,
  output logic                  accept_last,
  output logic                  drain_last
);
  import hadr_pkg::*;

  localparam int PW = $clog2(LOG2D) + 1;
  localparam logic [LOG2D-1:0] IDX_END  = LOG2D'(D - 1);
  localparam logic [PW-1:0]    PASS_END = PW'(LOG2D - 1);

  phase_e           phase_q;
  logic [LOG2D-1:0] idx_q;
  logic [PW-1:0]    pass_q;

  assign phase        = phase_q;
  assign elem_idx     = idx_q;
  assign accept       = (phase_q == PH_LOAD) && in_valid;
  assign accept_first = accept && (idx_q == '0);
  assign accept_last  = accept && (idx_q == IDX_END);
  assign drain_last   = (phase_q == PH_DRAIN) && (idx_q == IDX_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      idx_q   <= '0;
      pass_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_LOAD: begin
          if (accept) begin
            idx_q <= idx_q + 1'b1;
            if (accept_last) phase_q <= PH_SIGN;
          end
        end
        PH_SIGN: begin
          pass_q  <= '0;
          phase_q <= PH_XFORM;
        end
        PH_XFORM: begin
          pass_q <= pass_q + 1'b1;
          if (pass_q == PASS_END) phase_q <= PH_DRAIN;
        end
        PH_DRAIN: begin
          idx_q <= idx_q + 1'b1;
          if (drain_last) phase_q <= PH_LOAD;
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  // R5: passes advance one per cycle until the drain begins
  pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_XFORM && pass_q != PASS_END) |=>
      (phase_q == PH_XFORM && pass_q == $past(pass_q) + 1'b1));

  // R7: the last pass hands over to the drain with index zero
  pass_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_XFORM && pass_q == PASS_END) |=>
      (phase_q == PH_DRAIN && idx_q == '0));

  // R7: the sign step is a single cycle followed by the transform
  sign_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SIGN) |=> (phase_q == PH_XFORM && pass_q == '0));

endmodule

// File: rtl/hadamard_rotator.sv
module hadamard_rotator #(
  parameter int D           = 128,
  parameter int IW          = 16,
  parameter int LW          = 5,
  parameter int SCALE_SHIFT = 3
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_valid,
  output logic                                        in_ready,
  input  logic signed [IW-1:0]                        in_data,
  input  logic [LW-1:0]                               layer_sel,
  output logic                                        out_valid,
  output logic                                        out_last,
  output logic signed [IW+$clog2(D)-SCALE_SHIFT:0]    out_data
);
  import hadr_pkg::*;

  localparam int LOG2D = $clog2(D);
  localparam int AW    = IW + LOG2D + 1;
  localparam int OW    = AW - SCALE_SHIFT;
  localparam logic signed [AW-1:0] RND = AW'((1 << SCALE_SHIFT) >> 1);

  // Rounded arithmetic down-scale of one transform result.
  function automatic logic signed [OW-1:0] scale_round(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] t;
    t = v + RND;
    return OW'(t >>> SCALE_SHIFT);
  endfunction

  phase_e           phase;
  logic [LOG2D-1:0] elem_idx;
  logic             accept;
  logic             accept_first;
  logic             accept_last;
  logic             drain_last;

  hadr_ctrl #(.D(D), .LOG2D(LOG2D)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .phase        (phase),
    .elem_idx     (elem_idx),
    .accept       (accept),
    .accept_first (accept_first),
    .accept_last  (accept_last),
    .drain_last   (drain_last)
  );

  logic [LW-1:0] layer_q;
  logic [D-1:0]  flip_mask;

  hadr_sign_rom #(.D(D), .LW(LW)) rom_i (
    .layer (layer_q),
    .mask  (flip_mask)
  );

  logic signed [AW-1:0] vec_q   [D];
  logic signed [AW-1:0] stage_y [D];
  logic                 stage_ovf;

  hadr_shuffle_stage #(.D(D), .AW(AW)) stage_i (
    .x   (vec_q),
    .y   (stage_y),
    .ovf (stage_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) layer_q <= '0;
    else if (accept_first) layer_q <= layer_sel;
  end

  always_ff @(posedge clk) begin
    unique case (phase)
      PH_LOAD: begin
        if (accept) vec_q[elem_idx] <= AW'(in_data);
      end
      PH_SIGN: begin
        for (int i = 0; i < D; i++)
          vec_q[i] <= flip_mask[i] ? -vec_q[i] : vec_q[i];
      end
      PH_XFORM: vec_q <= stage_y;
      default: ;
    endcase
  end

  assign in_ready  = (phase == PH_LOAD);
  assign out_valid = (phase == PH_DRAIN);
  assign out_last  = drain_last;
  assign out_data  = scale_round(vec_q[elem_idx]);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid && !out_last));

  // R2
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_last |=> !in_ready);

  // R2
  ready_vs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R7
  last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R2
  last_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (in_ready && !out_valid));

  // R3
  layer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_first |=> $stable(layer_q));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_XFORM) |-> !stage_ovf);

endmodule

// File: tb/hadamard_rotator_tb_top.sv
module hadamard_rotator_tb_top;

  localparam int D     = 128;
  localparam int IW    = 16;
  localparam int LW    = 5;
  localparam int LOG2D = 7;
  localparam int OW    = 21;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [IW-1:0] in_data = '0;
  logic [LW-1:0]        layer_sel = '0;
  logic                 out_valid;
  logic                 out_last;
  logic signed [OW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  longint vec_in [D];
  longint expv   [D];

  always #10 clk = ~clk;

  hadamard_rotator #(.D(D), .IW(IW), .LW(LW), .SCALE_SHIFT(3)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .layer_sel (layer_sel),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_data  (out_data)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles exp at most 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  // Sign rule restated as a shift-and-mask form.
  function automatic bit neg_of(input int layer, input int j);
    int h;
    h = (j * j + 5 * layer * j + 3 * layer + 1) % 256;
    return bit'(((h >> 5) ^ (h >> 2)) & 1);
  endfunction

  function automatic bit odd_par(input int v);
    int c = 0;
    for (int b = 0; b < 16; b++) c += (v >> b) & 1;
    return bit'(c & 1);
  endfunction

  task automatic compute_expected(input int layer);
    for (int i = 0; i < D; i++) begin
      longint acc = 0;
      for (int j = 0; j < D; j++) begin
        longint z = neg_of(layer, j) ? -vec_in[j] : vec_in[j];
        acc += odd_par(i & j) ? -z : z;
      end
      expv[i] = (acc + 4) >>> 3;
    end
  endtask

  // Feeds vec_in, then collects and checks one output vector.
  task automatic run_vector(input int layer, input int alt_layer, input bit junk,
                            input string req);
    int n;
    compute_expected(layer);
    for (int j = 0; j < D; j++) begin
      check("R2 ready during load", in_ready, 1);
      in_valid  = 1'b1;
      in_data   = IW'(vec_in[j]);
      layer_sel = (j == 0) ? LW'(layer) : LW'(alt_layer);
      @(negedge clk);
    end
    in_valid = junk;
    in_data  = IW'($urandom);
    check("R2 ready low after vector", in_ready, 0);
    n = 1;
    while (!out_valid && n < 50) begin
      in_data   = IW'($urandom);
      layer_sel = LW'($urandom);
      @(negedge clk);
      n++;
    end
    check("R7 latency", n, LOG2D + 2);
    for (int i = 0; i < D; i++) begin
      check(req, longint'(out_data), expv[i]);
      check("R7 last flag", out_last, (i == D - 1) ? 1 : 0);
      if (i == 0) check("R7 valid", out_valid, 1);
      if (i == 0) check("R2 ready low in drain", in_ready, 0);
      in_data = IW'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R7 valid ends", out_valid, 0);
    check("R2 ready returns", in_ready, 1);
  endtask

  task automatic t_reset();
    check("R1 in_ready", in_ready, 1);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_last", out_last, 0);
  endtask

  task automatic t_impulse();
    for (int j = 0; j < D; j++) vec_in[j] = (j == 0) ? 1000 : 0;
    run_vector(0, 0, 1'b0, "R5 impulse");
    for (int j = 0; j < D; j++) vec_in[j] = (j == 77) ? -2000 : 0;
    run_vector(3, 3, 1'b0, "R5 shifted impulse");
  endtask

  task automatic t_ramp();
    for (int j = 0; j < D; j++) vec_in[j] = j * 37 - 2300;
    run_vector(1, 1, 1'b0, "R5 ramp");
  endtask

  task automatic t_random_layers();
    for (int j = 0; j < D; j++) vec_in[j] = longint'($signed(16'($urandom)));
    run_vector(31, 31, 1'b0, "R4 layer 31");
    run_vector(12, 12, 1'b0, "R4 layer 12");
  endtask

  task automatic t_full_scale();
    for (int j = 0; j < D; j++) vec_in[j] = neg_of(9, j) ? -32768 : 32767;
    run_vector(9, 9, 1'b0, "R6 near full scale");
    for (int j = 0; j < D; j++) vec_in[j] = -32768;
    run_vector(0, 0, 1'b0, "R6 all negative extreme");
  endtask

  task automatic t_layer_change();
    for (int j = 0; j < D; j++) vec_in[j] = longint'($signed(16'($urandom)));
    run_vector(5, 22, 1'b0, "R3 layer_sel ignored after element 0");
  endtask

  task automatic t_junk_while_busy();
    for (int j = 0; j < D; j++) vec_in[j] = (j % 5) * 911 - 1800;
    run_vector(17, 17, 1'b1, "R8 junk while busy, same vector");
    for (int j = 0; j < D; j++) vec_in[j] = 300 - j * 11;
    run_vector(2, 2, 1'b0, "R8 next vector after junk");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_impulse();
    t_ramp();
    t_random_layers();
    t_full_scale();
    t_layer_change();
    t_junk_while_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule